// File: doc/BRIEF.md
# Clock-Slave Serial Audio Transmitter with Alternating-Buffer Refill

This block sends stereo PCM samples out on an I2S serial line while a remote source supplies both the bit clock and the word-select clock. The block never derives either clock from its own system clock. Samples pass through a 32-entry dual-clock FIFO. Each entry holds one channel sample and a tag that says which channel it belongs to. On the system-clock side, a refill engine keeps the FIFO filled by reading words from two memory regions in strict turn. When one region is exhausted, the engine moves straight to the other region. It pulses a per-region done output so that software can reload the idle region, and it re-arms nothing by itself.

Word-select low marks the left slot. The MSB of a slot appears in the bit period that follows the word-select transition. A frame is only started when a complete left/right pair is already waiting. If the pair is missing after playback has begun, the block sends a silent frame and latches an underrun flag. It never sends a half frame and never swaps the channels.

The memory port is a request/acknowledge read port. The engine raises `mem_req_o` with `mem_addr_o` and keeps both steady until the memory asserts `mem_ack_i`. In the cycle that carries the acknowledge, `mem_rdata_i` is taken and written into the FIFO. At most one read is outstanding at a time, so the memory applies back-pressure simply by delaying the acknowledge. The memory must drive `mem_ack_i` only while a request is pending.

Top module: `i2s_slave_tx`

## Requirements
- R1: Each slot carries the sample MSB first. The MSB is driven on the falling bit-clock edge that follows the rising edge where the word-select change is seen, so a receiver that samples on rising edges takes the MSB one bit period after the transition.
- R2: The FIFO holds 32 channel samples, each with a channel tag (0 = left, 1 = right). Its pointers cross the clock domains in Gray code, and it is never written while full.
- R3: Refill reading starts when the write-side FIFO level is 16 or less and continues until the FIFO is full. One read is outstanding at a time, and `mem_req_o` and `mem_addr_o` stay steady until `mem_ack_i`.
- R4: Reads go through a region at base, base+1, …, base+len−1. The next read then comes from the other region's base, with no action from software. `done_o[r]` pulses for exactly one cycle, in the cycle after the acknowledge of region r's last word.
- R5: A pulse on `arm_i[r]` captures `base_i[r]` and `len_i[r]` only if region r is not armed and the length is nonzero; otherwise the pulse is ignored. A region that has been used up stays unarmed until it is armed again, and the engine waits on it if it is next in turn.
- R6: `starve_o` is high while the block is enabled and neither region is armed.
- R7: Words are sent in the order they were fetched, alternating left and right, with the first fetched word on a left slot (word-select low). Every word leaving the FIFO carries the tag of the slot it is sent in.
- R8: After playback has begun, if fewer than two words are waiting at the start of a left slot, both slots of that frame carry zero and `underrun_o` goes high and stays high. Playback resumes at a later left slot once a pair is present.
- R9: With `en_i` low, no new reads are issued, the serial output carries zero, and `underrun_o` is cleared.
- R10: During and after reset, `sd_o`, `mem_req_o`, `done_o` and `underrun_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Playback enable |
| arm_i | input | 2 | Per-region arm pulse |
| base_i | input | 2×ADDR_W | Per-region base word address |
| len_i | input | 2×LEN_W | Per-region length in words |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Read word address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | DATA_W | Read data |
| done_o | output | 2 | Per-region done pulse |
| starve_o | output | 1 | No region armed |
| underrun_o | output | 1 | Sticky underrun flag |
| bclk_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select (low = left) |
| sd_o | output | 1 | Serial data |

## Verification
Some properties are checked on every edge of their own clock. These are: the FIFO is never written while full and never read while empty; the Gray pointers move at most one bit per step; a request holds its address until it is acknowledged and only targets an armed region; done pulses last one cycle and never coincide; every word that leaves the FIFO carries the tag of its slot; and the underrun flag stays latched. Other behaviour can only be shown by the bench's scenarios. These are: the exact word order across region switches, whether arm pulses are accepted or ignored, a silent frame followed by recovery on a left slot, and the pause clearing the flag. The bench shows them by decoding the serial stream and comparing it with the sequence of addresses it served.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
  localparam int unsigned NUM_REGIONS = 2;
endpackage

// File: rtl/i2s_tx_cdc_fifo.sv
module i2s_tx_cdc_fifo #(
  parameter int unsigned DW = 33,
  parameter int unsigned AW = 5
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic [AW:0]   wlevel,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [AW:0]   rlevel
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE_L   = (AW+1)'(1);

  logic [DW-1:0] store [DEPTH];
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] rgray_m, rgray_s, wgray_m, wgray_s;
  logic [AW:0] wbin_nx, rbin_nx;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign wbin_nx = wbin + ONE_L;
  assign rbin_nx = rbin + ONE_L;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rgray_m <= '0; rgray_s <= '0;
    end else begin
      rgray_m <= rgray;
      rgray_s <= rgray_m;
      if (push) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (push) store[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wgray_m <= '0; wgray_s <= '0;
    end else begin
      wgray_m <= wgray;
      wgray_s <= wgray_m;
      if (pop) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end

  assign rdata  = store[rbin[AW-1:0]];
  assign wlevel = wbin - g2b(rgray_s);
  assign rlevel = g2b(wgray_s) - rbin;

  // R2: never written while full, never read while empty
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    push |-> (wlevel < DEPTH_L));
  p_no_underflow_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    pop |-> (rlevel != '0));
  // R2: Gray pointers change by at most one bit per step
  p_wgray_step_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  p_rgray_step_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/i2s_tx_refill.sv
module i2s_tx_refill
  import i2s_tx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned FAW    = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en_i,
  input  logic [NUM_REGIONS-1:0]             arm_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_REGIONS-1:0][LEN_W-1:0]  len_i,
  input  logic [FAW:0]                       fifo_level_i,
  output logic                               push_o,
  output logic [DW:0]                        push_data_o,
  output logic                               mem_req_o,
  output logic [ADDR_W-1:0]                  mem_addr_o,
  input  logic                               mem_ack_i,
  input  logic [DW-1:0]                      mem_rdata_i,
  output logic [NUM_REGIONS-1:0]             done_o,
  output logic                               starve_o
);
  localparam logic [FAW:0]   DEPTH_L = (FAW+1)'(1 << FAW);
  localparam logic [FAW:0]   HALF_L  = (FAW+1)'(1 << (FAW-1));
  localparam logic [LEN_W-1:0] LONE  = LEN_W'(1);

  logic [NUM_REGIONS-1:0]             armed;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] rbase;
  logic [NUM_REGIONS-1:0][LEN_W-1:0]  rlen;
  logic                               cur;
  logic [LEN_W-1:0]                   offs;
  chan_e                              tag;
  logic                               filling, req_q, starve_q;
  logic [NUM_REGIONS-1:0]             done_q;
  logic                               last_word;

  assign last_word   = (offs == rlen[cur] - LONE);
  assign mem_req_o   = req_q;
  assign mem_addr_o  = rbase[cur] + ADDR_W'(offs);
  assign push_o      = req_q & mem_ack_i;
  assign push_data_o = {tag, mem_rdata_i};
  assign done_o      = done_q;
  assign starve_o    = starve_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= '0; rbase <= '0; rlen <= '0; cur <= 1'b0; offs <= '0;
      tag <= CH_LEFT; filling <= 1'b0; req_q <= 1'b0; done_q <= '0;
      starve_q <= 1'b0;
    end else begin
      done_q   <= '0;
      starve_q <= en_i && (armed == '0);
      for (int r = 0; r < int'(NUM_REGIONS); r++) begin
        if (arm_i[r] && !armed[r] && (len_i[r] != '0)) begin
          armed[r] <= 1'b1;
          rbase[r] <= base_i[r];
          rlen[r]  <= len_i[r];
        end
      end
      if (fifo_level_i <= HALF_L) filling <= 1'b1;
      else if (fifo_level_i == DEPTH_L) filling <= 1'b0;
      if (req_q) begin
        if (mem_ack_i) begin
          req_q <= 1'b0;
          tag   <= (tag == CH_LEFT) ? CH_RIGHT : CH_LEFT;
          if (last_word) begin
            offs        <= '0;
            armed[cur]  <= 1'b0;
            done_q[cur] <= 1'b1;
            cur         <= ~cur;
          end else begin
            offs <= offs + LONE;
          end
        end
      end else if (en_i && filling && armed[cur] && (fifo_level_i < DEPTH_L)) begin
        req_q <= 1'b1;
      end
    end
  end

  // R3: request and address hold until acknowledged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R3: a read is only in flight while the FIFO has room
  p_req_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (fifo_level_i < DEPTH_L));
  // R5: reads only target an armed region
  p_req_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> armed[cur]);
  // R4: done pulses last one cycle and never coincide
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != '0) |=> (done_o == '0));
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
  import i2s_tx_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned FAW = 5
) (
  input  logic          bclk_i,
  input  logic          rrst_n,
  input  logic          ws_i,
  input  logic          en_async_i,
  input  logic [FAW:0]  fifo_level_i,
  input  logic [DW:0]   fifo_data_i,
  output logic          pop_o,
  output logic          sd_o,
  output logic          underrun_o
);
  localparam logic [FAW:0] PAIR_L = (FAW+1)'(2);

  logic          en_m, en_s;
  logic          ws_prev, ws_seen;
  logic [DW-1:0] shreg;
  logic          frame_ok, started, urun, sd_q;
  logic          ws_edge, left_go, right_go;
  chan_e         head_tag;

  assign head_tag = chan_e'(fifo_data_i[DW]);
  assign ws_edge  = ws_seen && (ws_i != ws_prev);
  assign left_go  = ws_edge && !ws_i && en_s && (fifo_level_i >= PAIR_L)
                    && (head_tag == CH_LEFT);
  assign right_go = ws_edge && ws_i && frame_ok;
  assign pop_o    = left_go | right_go;
  assign sd_o     = sd_q;
  assign underrun_o = urun;

  always_ff @(posedge bclk_i or negedge rrst_n) begin
    if (!rrst_n) begin
      en_m <= 1'b0; en_s <= 1'b0; ws_prev <= 1'b0; ws_seen <= 1'b0;
      shreg <= '0; frame_ok <= 1'b0; started <= 1'b0; urun <= 1'b0;
    end else begin
      en_m    <= en_async_i;
      en_s    <= en_m;
      ws_prev <= ws_i;
      ws_seen <= 1'b1;
      if (ws_edge) begin
        if (!ws_i) begin
          frame_ok <= left_go;
          shreg    <= left_go ? fifo_data_i[DW-1:0] : '0;
          if (left_go) started <= 1'b1;
          else if (en_s && started) urun <= 1'b1;
        end else begin
          frame_ok <= 1'b0;
          shreg    <= right_go ? fifo_data_i[DW-1:0] : '0;
        end
      end else begin
        shreg <= {shreg[DW-2:0], 1'b0};
      end
      if (!en_s) begin
        started <= 1'b0;
        urun    <= 1'b0;
      end
    end
  end

  always_ff @(negedge bclk_i or negedge rrst_n) begin
    if (!rrst_n) sd_q <= 1'b0;
    else         sd_q <= shreg[DW-1];
  end

  // R7: every popped word carries the tag of its slot
  p_chan_match_r7: assert property (@(posedge bclk_i) disable iff (!rrst_n)
    pop_o |-> (fifo_data_i[DW] == ws_i));
  // R7: the right half of a started frame is always present
  p_pair_present_r7: assert property (@(posedge bclk_i) disable iff (!rrst_n)
    (ws_edge && ws_i && frame_ok) |-> (fifo_level_i != '0));
  // R8: underrun flag stays set while enabled
  p_urun_sticky_r8: assert property (@(posedge bclk_i) disable iff (!rrst_n)
    (urun && en_s) |=> urun);
endmodule

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIFO_AW = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en_i,
  input  logic [NUM_REGIONS-1:0]             arm_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_REGIONS-1:0][LEN_W-1:0]  len_i,
  output logic                               mem_req_o,
  output logic [ADDR_W-1:0]                  mem_addr_o,
  input  logic                               mem_ack_i,
  input  logic [DATA_W-1:0]                  mem_rdata_i,
  output logic [NUM_REGIONS-1:0]             done_o,
  output logic                               starve_o,
  output logic                               underrun_o,
  input  logic                               bclk_i,
  input  logic                               ws_i,
  output logic                               sd_o
);
  localparam int unsigned FDW = DATA_W + 1;

  logic [1:0]       rrst_pipe;
  logic             rrst_n;
  logic             push, pop;
  logic [FDW-1:0]   wdata, rdata;
  logic [FIFO_AW:0] wlevel, rlevel;
  logic             urun_b;
  logic [1:0]       urun_sync;

  always_ff @(posedge bclk_i or negedge rst_n) begin
    if (!rst_n) rrst_pipe <= '0;
    else        rrst_pipe <= {rrst_pipe[0], 1'b1};
  end
  assign rrst_n = rrst_pipe[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) urun_sync <= '0;
    else        urun_sync <= {urun_sync[0], urun_b};
  end
  assign underrun_o = urun_sync[1];

  i2s_tx_refill #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DW(DATA_W), .FAW(FIFO_AW)
  ) refill_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .arm_i(arm_i),
    .base_i(base_i), .len_i(len_i), .fifo_level_i(wlevel),
    .push_o(push), .push_data_o(wdata),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .starve_o(starve_o)
  );

  i2s_tx_cdc_fifo #(.DW(FDW), .AW(FIFO_AW)) fifo_i (
    .wclk(clk), .wrst_n(rst_n), .push(push), .wdata(wdata), .wlevel(wlevel),
    .rclk(bclk_i), .rrst_n(rrst_n), .pop(pop), .rdata(rdata), .rlevel(rlevel)
  );

  i2s_tx_shifter #(.DW(DATA_W), .FAW(FIFO_AW)) shifter_i (
    .bclk_i(bclk_i), .rrst_n(rrst_n), .ws_i(ws_i), .en_async_i(en_i),
    .fifo_level_i(rlevel), .fifo_data_i(rdata), .pop_o(pop),
    .sd_o(sd_o), .underrun_o(urun_b)
  );

  // R10: quiet outputs right after reset release
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!mem_req_o && (done_o == '0)));
endmodule

// File: tb/i2s_slave_tx_tb_top.sv
module i2s_slave_tx_tb_top;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 12;
  localparam int DATA_W = 32;

  logic clk = 1'b0, bclk = 1'b0, ws = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [1:0] arm = '0;
  logic [1:0][ADDR_W-1:0] base = '0;
  logic [1:0][LEN_W-1:0]  len = '0;
  logic mem_req, mem_ack = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [1:0] done;
  logic starve, underrun, sd;

  i2s_slave_tx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .arm_i(arm), .base_i(base), .len_i(len),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .done_o(done), .starve_o(starve),
    .underrun_o(underrun), .bclk_i(bclk), .ws_i(ws), .sd_o(sd));

  always #2 clk = ~clk;
  always #25 bclk = ~bclk;
  initial forever begin repeat (32) @(negedge bclk); ws = ~ws; end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] pat(input logic [ADDR_W-1:0] a);
    return {1'b1, a[14:0], ~a[7:0], 8'hA5};
  endfunction

  // behavioural model of region state and expected sample stream
  bit m_armed[2];
  int m_base[2], m_len[2];
  int m_cur = 0, m_offs = 0;
  logic [31:0] exp_q[$];
  bit last_flag = 0;
  int last_reg = 0, served = 0, played = 0, data_frames = 0, zero_frames = 0;
  bit feed = 0, chk_frames = 1, urun_ok = 0, rx_started = 0;

  task automatic arm_region(input int r, input int b, input int l);
    @(negedge clk);
    base[r] = ADDR_W'(b); len[r] = LEN_W'(l); arm[r] = 1'b1;
    if (!m_armed[r] && l != 0) begin m_armed[r] = 1; m_base[r] = b; m_len[r] = l; end
    @(negedge clk);
    arm[r] = 1'b0;
  endtask

  // memory responder and per-clock done comparison
  initial forever begin
    @(negedge clk);
    if (rst_n) chk(done == ((mem_ack && last_flag) ? 2'(1 << last_reg) : 2'b00),
                   "R4 done pulse", longint'(done), longint'(last_flag));
    if (mem_ack) begin
      mem_ack = 1'b0; last_flag = 0;
    end else if (mem_req) begin
      chk(m_armed[m_cur], "R5 read from unarmed region", m_cur, 1);
      chk(mem_addr == ADDR_W'(m_base[m_cur] + m_offs), "R4 R5 read address",
          longint'(mem_addr), longint'(m_base[m_cur] + m_offs));
      mem_rdata = pat(mem_addr);
      exp_q.push_back(pat(mem_addr));
      served++;
      last_flag = (m_offs == m_len[m_cur] - 1);
      last_reg = m_cur;
      if (last_flag) begin m_armed[m_cur] = 0; m_cur ^= 1; m_offs = 0; end
      else m_offs++;
      mem_ack = 1'b1;
    end
  end

  // software agent re-arming used regions
  int next_base = 'h300;
  initial forever begin
    @(negedge clk);
    if (feed && done != 2'b00) begin
      next_base += 'h40;
      arm_region(done[1] ? 1 : 0, next_base, (next_base[6] ? 6 : 7));
    end
  end

  // serial receiver, frame checker
  logic [31:0] acc = '0, lw = '0;
  int cnt = 0;
  bit wsp = 0, have_left = 0;
  initial forever begin
    @(posedge bclk);
    if (ws != wsp) begin
      if (cnt == 31) begin
        logic [31:0] w;
        w = {acc[30:0], sd};
        if (!wsp) begin lw = w; have_left = 1; end
        else if (have_left) begin
          have_left = 0;
          if (chk_frames) begin
            if (lw == 0 && w == 0) begin
              zero_frames++;
              if (rx_started && !urun_ok) chk(0, "R8 unexpected silent frame", 0, 1);
            end else if (exp_q.size() < 2) begin
              chk(0, "R7 data with no fetched word", longint'(lw), 0);
            end else begin
              logic [31:0] el, er;
              el = exp_q.pop_front(); er = exp_q.pop_front();
              chk(lw == el, "R1 R7 left slot word", longint'(lw), longint'(el));
              chk(w == er, "R1 R7 right slot word", longint'(w), longint'(er));
              rx_started = 1; data_frames++; played += 2;
            end
          end
        end
      end
      acc = '0; cnt = 0;
    end else begin
      acc = {acc[30:0], sd}; cnt++;
    end
    wsp = ws;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    int dz;
    repeat (10) @(negedge clk);
    chk(!mem_req && done == 0 && !underrun && !sd && !starve, "R10 reset state",
        longint'({mem_req, done, underrun, sd}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mem_req && done == 0 && !underrun, "R10 after release", longint'(mem_req), 0);
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk(starve == 1'b1, "R6 starve with no region", longint'(starve), 1);
    arm_region(0, 'h100, 0);
    repeat (50) @(negedge clk);
    chk(starve == 1'b1 && !mem_req, "R5 zero-length arm ignored", longint'({starve, mem_req}), 2);
    arm_region(0, 'h100, 8);
    arm_region(1, 'h200, 7);
    arm_region(0, 'h900, 5);
    repeat (10) @(negedge clk);
    chk(starve == 1'b0, "R6 starve clears when armed", longint'(starve), 0);
    feed = 1;
    repeat (20000) @(negedge clk);
    chk(data_frames > 10, "R4 R7 continuous playback", data_frames, 11);
    chk(zero_frames >= 0 && !underrun, "R8 no underrun while fed", longint'(underrun), 0);
    chk(served - played <= 34 && served - played >= 15, "R3 FIFO kept between half and full",
        served - played, 24);
    feed = 0; urun_ok = 1;
    dz = zero_frames;
    repeat (25000) @(negedge clk);
    chk(underrun == 1'b1, "R8 underrun flagged", longint'(underrun), 1);
    chk(zero_frames > dz, "R8 silent frames sent", zero_frames, dz + 1);
    chk(starve == 1'b1, "R6 starve after both used", longint'(starve), 1);
    chk(!mem_req, "R5 used regions not reused", longint'(mem_req), 0);
    dz = data_frames;
    arm_region(m_cur, 'h2000, 9);
    arm_region(m_cur ^ 1, 'h3000, 8);
    repeat (10000) @(negedge clk);
    chk(data_frames > dz, "R8 playback resumes on a left slot", data_frames, dz + 1);
    chk(underrun == 1'b1, "R8 underrun sticky", longint'(underrun), 1);
    chk_frames = 0;
    en = 1'b0;
    repeat (300) @(negedge clk);
    begin
      bit quiet = 1;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (mem_req) quiet = 0;
      end
      chk(quiet, "R9 no reads while disabled", 0, 0);
    end
    chk(underrun == 1'b0, "R9 underrun cleared by disable", longint'(underrun), 0);
    begin
      bit silent = 1;
      for (int i = 0; i < 200; i++) begin
        @(posedge bclk);
        if (sd) silent = 0;
      end
      chk(silent, "R9 serial output zero while disabled", 1, 0);
    end
    finish_up();
  end
endmodule